// File: doc/BRIEF.md
# Shared EEPROM and PHY Access Engine

This block gives a host one small indirect window, four byte registers, through which it can reach either a serial configuration EEPROM or the management registers of an Ethernet PHY. The host puts a word or register address into the address register and, for writes, a 16-bit value into the two data bytes. It then sets a target bit and a read or write command bit in the control register, and polls a busy flag until the transfer is over. After a read the result sits in the data bytes. The host clears the command bits itself before it issues the next command.

A single serial bit engine, clocked by a divided system clock, runs both kinds of transfer. For the PHY it sends a 64-bit management frame and releases the data line during turnaround and read data. For the EEPROM it raises chip select and sends a start bit, a two-bit opcode and a six-bit word address, then either sends or receives 16 data bits. EEPROM writes are refused unless a write-enable bit is set. A reload command reads the first few EEPROM words in order and hands each one to neighbouring configuration logic on a strobe port.

Top module: `eephy_window`

## Requirements
- R1: After reset, all four window registers read 0, the busy bit (control bit 0) reads 0, and the serial clocks, chip select and data-line enable are low.
- R2: A command starts only on a 0-to-1 change of its control bit (read = bit 1, write = bit 2, reload = bit 5) while the engine is idle. A bit that stays set, or that rises while a transfer runs, starts nothing.
- R3: If the read and write bits rise in the same host write, a read is performed and no write takes place.
- R4: With control bit 3 clear, only the EEPROM pins move. With it set, only the management pins move.
- R5: A PHY read sends 32 ones, start 01, opcode 10, the 5-bit PHY address and register address bits 4:0, MSB first. The engine then releases the data line for the 2 turnaround bits and 16 data bits, and captures the data MSB first.
- R6: A PHY write sends the same header with opcode 01, turnaround 10 and the data {high byte, low byte} MSB first, and drives the line for all 64 bits.
- R7: The PHY address is {000, address register bits 7:6}. While the internal-PHY input is high the low two bits are 01 whatever the register holds.
- R8: An EEPROM transfer keeps chip select high for exactly 25 serial clocks: start bit 1, opcode (10 read, 01 write), address register bits 5:0, then 16 data bits MSB first.
- R9: An EEPROM write while control bit 4 (write enable) is clear is dropped: busy stays 0, no pin moves and the memory is unchanged. With bit 4 set the write completes.
- R10: When a read completes, the received word is in the data registers (offset 2 low byte, offset 3 high byte) no later than the cycle in which busy reads 0.
- R11: Busy reads 1 from the first register read after the command edge until the transfer completes.
- R12: A reload reads EEPROM words 0 to RELOAD_WORDS-1 in order. Each word appears once on the configuration port with its index, and busy is held until the last word.
- R13: Each serial clock high phase lasts exactly CLK_DIV system clocks, and the serial data output never changes while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 2 | Register offset: 0 control, 1 address, 2 data low, 3 data high |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered read data for hst_addr |
| phy_internal | input | 1 | Selects the internal PHY (forces address bits to 01) |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Data to EEPROM |
| ee_do | input | 1 | Data from EEPROM |
| cfg_valid | output | 1 | One-cycle strobe for a reloaded word |
| cfg_index | output | IDX_W | Word index of the reloaded word |
| cfg_word | output | 16 | Reloaded word value |

## Verification
A sequencer that keeps a stale target or opcode shows up on the pins within one serial bit. It shows as the wrong header captured by the PHY or EEPROM model, or as the data line driven during turnaround. A lost or repeated command edge shows as a missing or extra frame at the models before the next host poll returns idle. A bad capture or a late data-register update shows in the first data read after busy falls. A reload counter fault shows as an out-of-order or missing word in the configuration scoreboard.

// File: rtl/eephy_pkg.sv
package eephy_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DLO  = 2'd2;
  localparam logic [1:0] REG_DHI  = 2'd3;

  localparam int C_RD  = 1;
  localparam int C_WR  = 2;
  localparam int C_PHY = 3;
  localparam int C_WEN = 4;
  localparam int C_RLD = 5;

  localparam int FRAME_W       = 64;
  localparam int CNT_W         = 7;
  localparam int MDIO_BITS     = 64;
  localparam int MDIO_RD_DRIVE = 46;
  localparam int EE_BITS       = 25;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} seq_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   nbits;
    logic [CNT_W-1:0]   ndrive;
  } frame_t;

  function automatic frame_t mdio_frame(input logic rd, input logic [4:0] phy,
                                        input logic [4:0] regad, input logic [15:0] wd);
    frame_t f;
    f.bits   = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    f.nbits  = CNT_W'(MDIO_BITS);
    f.ndrive = rd ? CNT_W'(MDIO_RD_DRIVE) : CNT_W'(MDIO_BITS);
    return f;
  endfunction

  function automatic frame_t ee_frame(input logic rd, input logic [5:0] wad,
                                      input logic [15:0] wd);
    frame_t f;
    f.bits   = {1'b1, (rd ? 2'b10 : 2'b01), wad, (rd ? 16'h0000 : wd),
                {(FRAME_W-EE_BITS){1'b0}}};
    f.nbits  = CNT_W'(EE_BITS);
    f.ndrive = CNT_W'(EE_BITS);
    return f;
  endfunction
endpackage

// File: rtl/eephy_regs.sv
module eephy_regs
  import eephy_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hst_we,
  input  logic [1:0]  hst_addr,
  input  logic [7:0]  hst_wdata,
  output logic [7:0]  hst_rdata,
  input  logic        busy,
  input  logic        res_valid,
  input  logic [15:0] res_data,
  output logic        tgt_phy,
  output logic        ee_wen,
  output logic [7:0]  addr_q,
  output logic [15:0] data_q,
  output logic        rd_edge,
  output logic        wr_edge,
  output logic        rld_edge
);
  logic rd_q, wr_q, rld_q;
  logic rd_p, wr_p, rld_p;
  logic [7:0] dlo_q, dhi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0; wr_q <= 1'b0; rld_q <= 1'b0;
      rd_p <= 1'b0; wr_p <= 1'b0; rld_p <= 1'b0;
      tgt_phy <= 1'b0; ee_wen <= 1'b0;
      addr_q <= '0; dlo_q <= '0; dhi_q <= '0;
      hst_rdata <= '0;
    end else begin
      rd_p  <= rd_q;
      wr_p  <= wr_q;
      rld_p <= rld_q;
      if (hst_we) begin
        case (hst_addr)
          REG_CTRL: begin
            rd_q    <= hst_wdata[C_RD];
            wr_q    <= hst_wdata[C_WR];
            tgt_phy <= hst_wdata[C_PHY];
            ee_wen  <= hst_wdata[C_WEN];
            rld_q   <= hst_wdata[C_RLD];
          end
          REG_ADDR: addr_q <= hst_wdata;
          REG_DLO:  dlo_q  <= hst_wdata;
          default:  dhi_q  <= hst_wdata;
        endcase
      end
      if (res_valid) begin
        dlo_q <= res_data[7:0];
        dhi_q <= res_data[15:8];
      end
      case (hst_addr)
        REG_CTRL: hst_rdata <= {2'b00, rld_q, ee_wen, tgt_phy, wr_q, rd_q, busy};
        REG_ADDR: hst_rdata <= addr_q;
        REG_DLO:  hst_rdata <= dlo_q;
        default:  hst_rdata <= dhi_q;
      endcase
    end
  end

  assign data_q   = {dhi_q, dlo_q};
  assign rd_edge  = rd_q  & ~rd_p;
  assign wr_edge  = wr_q  & ~wr_p;
  assign rld_edge = rld_q & ~rld_p;

  // R10: a finished read lands in the byte registers one edge later
  a_r10_result_landed: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (data_q == $past(res_data)));
  // R10: busy is still up while the result is being written
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);
  // R9: an EEPROM write without the enable never raises busy
  a_r9_unarmed_write: assert property (@(posedge clk) disable iff (rst)
    (wr_edge && !rd_edge && !rld_edge && !busy && !tgt_phy && !ee_wen) |=> !busy);
endmodule

// File: rtl/eephy_shifter.sv
module eephy_shifter
  import eephy_pkg::*;
#(
  parameter int CLK_DIV = 4,
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  frame_t           frame,
  input  logic             sin,
  output logic             active,
  output logic             sclk,
  output logic             sout,
  output logic             soe,
  output logic             done,
  output logic [15:0]      capt,
  output logic [CNT_W-1:0] bit_idx
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   nbits, ndrive;
  logic [DW-1:0]      div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; sclk <= 1'b0; sout <= 1'b0; soe <= 1'b0; done <= 1'b0;
      capt <= '0; bit_idx <= '0; shreg <= '0; nbits <= '0; ndrive <= '0; div_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        shreg   <= frame.bits;
        nbits   <= frame.nbits;
        ndrive  <= frame.ndrive;
        bit_idx <= '0;
        div_q   <= '0;
        sclk    <= 1'b0;
        sout    <= frame.bits[FRAME_W-1];
        soe     <= (frame.ndrive != '0);
      end else if (active) begin
        if (div_q == DW'(CLK_DIV-1)) begin
          div_q <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            capt <= {capt[14:0], sin};
          end else begin
            sclk <= 1'b0;
            if (bit_idx == nbits - CNT_W'(1)) begin
              active <= 1'b0;
              done   <= 1'b1;
              sout   <= 1'b0;
              soe    <= 1'b0;
            end else begin
              bit_idx <= bit_idx + CNT_W'(1);
              shreg   <= shreg << 1;
              sout    <= shreg[FRAME_W-2];
              soe     <= (bit_idx + CNT_W'(1)) < ndrive;
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  // R13: data out holds for the whole high phase
  a_r13_hold_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> ($stable(sout) && $stable(soe)));
  // R2: the sequencer only launches a frame into an idle engine
  a_r2_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
endmodule

// File: rtl/eephy_seq.sv
module eephy_seq
  import eephy_pkg::*;
#(
  parameter int RELOAD_WORDS = 4,
  localparam int IDX_W = (RELOAD_WORDS > 1) ? $clog2(RELOAD_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_edge,
  input  logic             wr_edge,
  input  logic             rld_edge,
  input  logic             tgt_phy,
  input  logic             ee_wen,
  input  logic [4:0]       phy_addr,
  input  logic [5:0]       word_addr,
  input  logic [15:0]      wdata,
  input  logic             sh_done,
  input  logic [15:0]      sh_capt,
  output logic             sh_start,
  output frame_t           sh_frame,
  output logic             tgt_q,
  output logic             op_rd_q,
  output logic             busy,
  output logic             res_valid,
  output logic [15:0]      res_data,
  output logic             cfg_valid,
  output logic [IDX_W-1:0] cfg_index,
  output logic [15:0]      cfg_word
);
  seq_state_e       state;
  logic             rld_q;
  logic [IDX_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; rld_q <= 1'b0; word_q <= '0;
      sh_start <= 1'b0; sh_frame <= '0; tgt_q <= 1'b0; op_rd_q <= 1'b0;
      res_valid <= 1'b0; res_data <= '0;
      cfg_valid <= 1'b0; cfg_index <= '0; cfg_word <= '0;
    end else begin
      sh_start  <= 1'b0;
      res_valid <= 1'b0;
      cfg_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rd_edge) begin
            tgt_q <= tgt_phy; op_rd_q <= 1'b1; rld_q <= 1'b0;
            sh_frame <= tgt_phy ? mdio_frame(1'b1, phy_addr, word_addr[4:0], wdata)
                                : ee_frame(1'b1, word_addr, wdata);
            sh_start <= 1'b1;
            state <= ST_XFER;
          end else if (wr_edge && (tgt_phy || ee_wen)) begin
            tgt_q <= tgt_phy; op_rd_q <= 1'b0; rld_q <= 1'b0;
            sh_frame <= tgt_phy ? mdio_frame(1'b0, phy_addr, word_addr[4:0], wdata)
                                : ee_frame(1'b0, word_addr, wdata);
            sh_start <= 1'b1;
            state <= ST_XFER;
          end else if (rld_edge) begin
            tgt_q <= 1'b0; op_rd_q <= 1'b1; rld_q <= 1'b1; word_q <= '0;
            sh_frame <= ee_frame(1'b1, 6'd0, 16'h0000);
            sh_start <= 1'b1;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            if (rld_q) begin
              cfg_valid <= 1'b1;
              cfg_index <= word_q;
              cfg_word  <= sh_capt;
              if (word_q == IDX_W'(RELOAD_WORDS-1)) begin
                state <= ST_FIN;
              end else begin
                word_q   <= word_q + IDX_W'(1);
                sh_frame <= ee_frame(1'b1, 6'(word_q) + 6'd1, 16'h0000);
                sh_start <= 1'b1;
              end
            end else begin
              if (op_rd_q) begin
                res_valid <= 1'b1;
                res_data  <= sh_capt;
              end
              state <= ST_FIN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R12: reload words leave in ascending order
  a_r12_reload_order: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && $past(cfg_valid, 1) == 1'b0 && busy && cfg_index != '0) |->
      (cfg_index == $past(word_q)));
endmodule

// File: rtl/eephy_window.sv
module eephy_window
  import eephy_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int RELOAD_WORDS = 4,
  localparam int IDX_W = (RELOAD_WORDS > 1) ? $clog2(RELOAD_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_we,
  input  logic [1:0]       hst_addr,
  input  logic [7:0]       hst_wdata,
  output logic [7:0]       hst_rdata,
  input  logic             phy_internal,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do,
  output logic             cfg_valid,
  output logic [IDX_W-1:0] cfg_index,
  output logic [15:0]      cfg_word
);
  logic        busy, res_valid, tgt_phy, ee_wen, rd_edge, wr_edge, rld_edge;
  logic [15:0] res_data, data_q, sh_capt;
  logic [7:0]  addr_q;
  logic        sh_start, sh_done, sh_active, sclk, sout, soe, tgt_q, op_rd_q, sin;
  frame_t      sh_frame;
  logic [CNT_W-1:0] bit_idx;
  logic [4:0]  phy_addr;

  assign phy_addr = {3'b000, (phy_internal ? 2'b01 : addr_q[7:6])};
  assign sin      = tgt_q ? mdio_i : ee_do;

  eephy_regs u_regs (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .tgt_phy(tgt_phy), .ee_wen(ee_wen), .addr_q(addr_q), .data_q(data_q),
    .rd_edge(rd_edge), .wr_edge(wr_edge), .rld_edge(rld_edge));

  eephy_seq #(.RELOAD_WORDS(RELOAD_WORDS)) u_seq (
    .clk(clk), .rst(rst), .rd_edge(rd_edge), .wr_edge(wr_edge), .rld_edge(rld_edge),
    .tgt_phy(tgt_phy), .ee_wen(ee_wen), .phy_addr(phy_addr), .word_addr(addr_q[5:0]),
    .wdata(data_q), .sh_done(sh_done), .sh_capt(sh_capt), .sh_start(sh_start),
    .sh_frame(sh_frame), .tgt_q(tgt_q), .op_rd_q(op_rd_q), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .cfg_valid(cfg_valid),
    .cfg_index(cfg_index), .cfg_word(cfg_word));

  eephy_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .frame(sh_frame), .sin(sin),
    .active(sh_active), .sclk(sclk), .sout(sout), .soe(soe), .done(sh_done),
    .capt(sh_capt), .bit_idx(bit_idx));

  assign mdc     = sclk & tgt_q;
  assign mdio_o  = sout & tgt_q;
  assign mdio_oe = soe & tgt_q;
  assign ee_cs   = sh_active & ~tgt_q;
  assign ee_sk   = sclk & ~tgt_q;
  assign ee_di   = sout & ~tgt_q;

  // R4: the two sides never move together
  a_r4_one_side: assert property (@(posedge clk) disable iff (rst)
    !(ee_cs && (mdc || mdio_oe)));
  // R1: pins are quiet whenever no transfer is in flight
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ee_cs && !ee_sk && !mdc && !mdio_oe));
  // R5: line released for turnaround and read data
  a_r5_turnaround_release: assert property (@(posedge clk) disable iff (rst)
    (sh_active && tgt_q && op_rd_q && bit_idx >= CNT_W'(MDIO_RD_DRIVE)) |-> !mdio_oe);
endmodule

// File: tb/eephy_window_bench.sv
module eephy_window_bench;
  localparam int CLK_DIV = 4;
  localparam int RLD_N   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       hst_we = 1'b0;
  logic [1:0] hst_addr = 2'd0;
  logic [7:0] hst_wdata = 8'd0;
  logic [7:0] hst_rdata;
  logic       phy_internal = 1'b0;
  logic       mdc, mdio_o, mdio_oe, mdio_i, ee_cs, ee_sk, ee_di, ee_do;
  logic       cfg_valid;
  logic [1:0] cfg_index;
  logic [15:0] cfg_word;

  eephy_window #(.CLK_DIV(CLK_DIV), .RELOAD_WORDS(RLD_N)) u_eephy_window (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .phy_internal(phy_internal), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .cfg_valid(cfg_valid), .cfg_index(cfg_index), .cfg_word(cfg_word));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // EEPROM model
  logic [15:0] ee_mem [64];
  int          ee_cnt = 0;
  logic [8:0]  ee_cmd = '0;
  logic [8:0]  ee_last_cmd = '0;
  logic [15:0] ee_wsh = '0;
  int          ee_frames = 0;
  int          ee_last_bits = 0;
  logic        ee_do_r = 1'b0;
  assign ee_do = ee_do_r;

  always @(posedge ee_cs) if (!rst) begin ee_cnt = 0; ee_cmd = '0; end
  always @(posedge ee_sk) if (!rst && ee_cs) begin
    if (ee_cnt < 9) ee_cmd = {ee_cmd[7:0], ee_di};
    else ee_wsh = {ee_wsh[14:0], ee_di};
    ee_cnt++;
  end
  always @(negedge ee_sk) if (!rst && ee_cs) begin
    if (ee_cmd[8] && ee_cmd[7:6] == 2'b10 && ee_cnt >= 9 && ee_cnt < 25)
      ee_do_r = ee_mem[ee_cmd[5:0]][15-(ee_cnt-9)];
  end
  always @(negedge ee_cs) if (!rst) begin
    ee_frames++;
    ee_last_bits = ee_cnt;
    ee_last_cmd  = ee_cmd;
    if (ee_cmd[8] && ee_cmd[7:6] == 2'b01 && ee_cnt == 25) ee_mem[ee_cmd[5:0]] = ee_wsh;
    ee_do_r = 1'b0;
  end

  // management PHY model, answers at PHY address 1 only
  logic [15:0] phy_mem [32];
  int          md_cnt = 0;
  logic [45:0] md_hdr = '0;
  logic [45:0] md_last_hdr = '0;
  logic [15:0] md_wsh = '0;
  int          md_frames = 0;
  logic        md_drv_en = 1'b0;
  logic        md_drv = 1'b1;
  int          md_conflicts = 0;
  assign mdio_i = md_drv_en ? md_drv : 1'b1;

  always @(posedge mdc) if (!rst) begin
    if (md_cnt < 46) md_hdr = {md_hdr[44:0], mdio_o};
    else if (md_cnt >= 48) md_wsh = {md_wsh[14:0], mdio_o};
    md_cnt++;
    if (md_cnt == 64) begin
      md_frames++;
      md_last_hdr = md_hdr;
      if (md_hdr[11:10] == 2'b01 && md_hdr[9:5] == 5'd1) phy_mem[md_hdr[4:0]] = md_wsh;
      md_cnt = 0;
    end
  end
  always @(negedge mdc) if (!rst) begin
    if (md_cnt >= 47 && md_hdr[11:10] == 2'b10 && md_hdr[9:5] == 5'd1) begin
      md_drv_en = 1'b1;
      md_drv = (md_cnt == 47) ? 1'b0 : phy_mem[md_hdr[4:0]][15-(md_cnt-48)];
    end else begin
      md_drv_en = 1'b0;
    end
  end

  // serial clock timing monitor
  int   hi_run = 0, hi_samples = 0, hi_viol = 0, sout_viol = 0;
  logic prev_sck = 1'b0, prev_out = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (md_drv_en && mdio_oe) md_conflicts++;
    if (mdc || ee_sk) begin
      hi_run++;
      if (prev_sck && ((mdc ? mdio_o : ee_di) != prev_out)) sout_viol++;
    end else if (prev_sck) begin
      hi_samples++;
      if (hi_run != CLK_DIV) hi_viol++;
      hi_run = 0;
    end
    prev_sck = mdc || ee_sk;
    prev_out = mdc ? mdio_o : ee_di;
  end

  // scoreboard for reloaded words
  logic [31:0] sb_q[$];
  int          cfg_seen = 0;
  always @(negedge clk) if (!rst && cfg_valid) begin
    cfg_seen++;
    if (sb_q.size() == 0) begin
      chk("R12", "unexpected reload word", {14'd0, cfg_index, cfg_word}, 32'hFFFF_FFFF);
    end else begin
      chk("R12", "reload word", (32'(cfg_index) << 16) | 32'(cfg_word), sb_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hst_addr = a;
    @(negedge clk); d = hst_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(2'd0, c);
      if (!c[0]) break;
    end
  endtask

  task automatic rd_data(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(2'd2, lo);
    rd_reg(2'd3, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] v;
    int f0, m0;
    for (int i = 0; i < 64; i++) ee_mem[i] = 16'((i * 16'h0103) ^ 16'h3C5A);
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), r);
      chk("R1", "register after reset", 32'(r), 32'd0);
    end
    chk("R1", "pins idle", {28'd0, mdc, mdio_oe, ee_cs, ee_sk}, 32'd0);

    // R8 R10 EEPROM read
    m0 = md_frames;
    wr_reg(2'd1, 8'd5);
    wr_reg(2'd0, 8'h02);
    wait_idle();
    rd_data(v);
    chk("R10", "eeprom read data", 32'(v), 32'(ee_mem[5]));
    chk("R8", "eeprom clocks", ee_last_bits, 25);
    chk("R8", "eeprom command", 32'(ee_last_cmd), {23'd0, 1'b1, 2'b10, 6'd5});
    chk("R4", "no mgmt frame on eeprom read", md_frames, m0);

    // R2 held bit does not restart
    f0 = ee_frames;
    wr_reg(2'd0, 8'h02);
    repeat (300) @(negedge clk);
    chk("R2", "held read bit restarted", ee_frames, f0);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd0, 8'h02);
    wait_idle();
    chk("R2", "fresh edge starts", ee_frames, f0 + 1);

    // R9 unarmed and armed EEPROM write
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd1, 8'd9);
    wr_reg(2'd2, 8'hCD);
    wr_reg(2'd3, 8'hAB);
    f0 = ee_frames;
    v = ee_mem[9];
    wr_reg(2'd0, 8'h04);
    repeat (300) @(negedge clk);
    rd_reg(2'd0, r);
    chk("R9", "busy without enable", 32'(r[0]), 32'd0);
    chk("R9", "frames without enable", ee_frames, f0);
    chk("R9", "memory without enable", 32'(ee_mem[9]), 32'(v));
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd0, 8'h14);
    wait_idle();
    chk("R9", "armed write stored", 32'(ee_mem[9]), 32'hABCD);
    chk("R8", "write clocks", ee_last_bits, 25);

    // R11 busy visible right after the command
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd0, r);
    chk("R11", "busy after command", 32'(r[0]), 32'd1);
    wait_idle();

    // R6 R7 PHY write
    f0 = ee_frames;
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd1, 8'h43);
    wr_reg(2'd2, 8'h34);
    wr_reg(2'd3, 8'h12);
    wr_reg(2'd0, 8'h0C);
    wait_idle();
    chk("R6", "phy write stored", 32'(phy_mem[3]), 32'h1234);
    chk("R6", "write header", 32'(md_last_hdr[13:0]), {18'd0, 2'b01, 2'b01, 5'd1, 5'd3});
    chk("R5", "preamble", md_last_hdr[45:14], 32'hFFFF_FFFF);
    chk("R4", "no eeprom frame on phy", ee_frames, f0);

    // R5 R10 PHY read
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h0A);
    wait_idle();
    rd_data(v);
    chk("R10", "phy read data", 32'(v), 32'h1234);
    chk("R5", "read opcode", 32'(md_last_hdr[11:10]), 32'd2);
    chk("R5", "drive conflicts", md_conflicts, 0);

    // R3 read wins
    phy_mem[7] = 16'hBEEF;
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd1, 8'h47);
    wr_reg(2'd0, 8'h0E);
    wait_idle();
    rd_data(v);
    chk("R3", "read data", 32'(v), 32'hBEEF);
    chk("R3", "opcode", 32'(md_last_hdr[11:10]), 32'd2);
    chk("R3", "register untouched", 32'(phy_mem[7]), 32'hBEEF);

    // R7 address forcing
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd1, 8'h83);
    wr_reg(2'd0, 8'h0A);
    wait_idle();
    rd_data(v);
    chk("R7", "phy address from register", 32'(md_last_hdr[9:5]), 32'd2);
    chk("R7", "absent phy data", 32'(v), 32'hFFFF);
    phy_internal = 1'b1;
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd0, 8'h0A);
    wait_idle();
    rd_data(v);
    chk("R7", "internal phy address", 32'(md_last_hdr[9:5]), 32'd1);
    chk("R7", "internal phy data", 32'(v), 32'h1234);
    phy_internal = 1'b0;

    // R2 edge during a transfer is dropped
    m0 = md_frames;
    wr_reg(2'd0, 8'h08);
    wr_reg(2'd1, 8'h43);
    wr_reg(2'd0, 8'h0A);
    wr_reg(2'd0, 8'h0E);
    wait_idle();
    repeat (600) @(negedge clk);
    chk("R2", "frames with edge while busy", md_frames, m0 + 1);

    // R12 reload
    wr_reg(2'd0, 8'h00);
    for (int i = 0; i < RLD_N; i++) sb_q.push_back((32'(i) << 16) | 32'(ee_mem[i]));
    cfg_seen = 0;
    wr_reg(2'd0, 8'h20);
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R12", "reload words seen", cfg_seen, RLD_N);
    chk("R12", "scoreboard drained", sb_q.size(), 0);

    // R13 serial timing
    chk("R13", "high phase samples present", 32'(hi_samples > 0), 32'd1);
    chk("R13", "high phase length errors", hi_viol, 0);
    chk("R13", "data change while high", sout_viol, 0);

    summary();
  end
endmodule